// File: doc/BRIEF.md
# Color Palette Lookup with Host Register Port

This block keeps a table of 256 colors, each made of three 6-bit components (red, green, blue) packed into 18 bits. A pixel stream presents one 8-bit index per clock. The index is ANDed with a programmable mask, and the selected color appears on the output one clock later.

A byte-wide host port, with a 3-bit register select and single-cycle read and write strobes, loads and inspects the table. The host moves one component per transfer, always in the order red, green, blue. The table position advances by itself after every third component, so a whole run of entries can be streamed in or out after setting the start position once. Reads are prefetched: the entry is fetched into a shared 18-bit buffer before the host asks for its first component.

The table has one lookup port. When a host transfer needs the table, the pixel stream loses that clock and the color output holds its last value. The pixel stream uses valid-only flow control. There is no back-pressure: an index is accepted on every clock in which `pix_valid` is high, and `color_valid` repeats `pix_valid` one clock later. If a host strobe and a read strobe arrive in the same cycle, the write is taken and the read is ignored.

Top module: `clut_engine`

## Requirements
- R1: After reset the mask reads 0xFF, the table position reads 0, the component step is red, `color` is 0 and `color_valid` is 0.
- R2: A write to select 0 loads the table position and returns the component step to red. Reading select 0 or select 3 returns the same table position.
- R3: A write to select 3 copies the table entry at the written value into the buffer, leaves the step at red, and sets the position to the written value plus 1, counted modulo 256.
- R4: Writes to select 1 take data bits 5..0 as red, then green, then blue. The blue write stores {red, green, blue} at the current position, then advances the position modulo 256 and returns the step to red.
- R5: Reads of select 1 return the buffered red, then green, then blue in bits 5..0, with bits 7..6 always 0. The blue read reloads the buffer from the entry at the current position, then advances the position modulo 256.
- R6: Select 2 holds the pixel mask, which can be written and read back. The looked-up entry is `pix_idx & mask`.
- R7: The mask never alters positions set or advanced by the host.
- R8: When `pix_valid` is high, the next clock shows the table entry on `color` (red in bits 17..12, green in 11..6, blue in 5..0) with `color_valid` high. `color_valid` repeats `pix_valid` one clock later.
- R9: A clock that uses the table for a host transfer does not update `color`. This covers a select 3 write, a blue write and a blue read. The previous color is repeated.
- R10: Selects 4 to 7 read as 0, and writes to them change neither the position nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the host and pixel sides |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 3 | Register select |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one clock per transfer |
| host_rd | input | 1 | Read strobe, one clock per transfer |
| host_rdata | output | 8 | Read data for the selected register |
| pix_valid | input | 1 | Pixel index valid |
| pix_idx | input | 8 | Pixel index |
| color_valid | output | 1 | Output color valid |
| color | output | 18 | Looked-up color {red, green, blue} |

## Verification
The hardest case to reach is a host transfer that takes the table in the same clock as a live pixel index. When that happens, the pixel is dropped and the previous color must be held. The stimulus lines up a select 3 write, and separately a blue component write, on the very clock that a new pixel index is presented. It then checks the held color on that clock, a normal lookup on the next clock, and that the blue write's new entry shows up in the lookup that follows. The full-table fill and readback runs the position through its wrap from 255 to 0.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_t;

  localparam logic [2:0] SEL_WPOS  = 3'd0;
  localparam logic [2:0] SEL_COLOR = 3'd1;
  localparam logic [2:0] SEL_MASK  = 3'd2;
  localparam logic [2:0] SEL_RPOS  = 3'd3;
endpackage

// File: rtl/clut_host_regs.sv
module clut_host_regs
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  localparam int WORD_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_sel,
  input  logic [IDX_W-1:0]  host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [IDX_W-1:0]  host_rdata,
  output logic [IDX_W-1:0]  pix_mask,
  output logic              acc_en,
  output logic              acc_we,
  output logic [IDX_W-1:0]  acc_addr,
  output logic [WORD_W-1:0] acc_wword,
  input  logic [WORD_W-1:0] acc_rword
);
  localparam int PAD_W = IDX_W - COMP_W;

  phase_t             phase_q;
  logic [IDX_W-1:0]   pos_q;
  logic [IDX_W-1:0]   mask_q;
  logic [COMP_W-1:0]  red_q, grn_q, blu_q;
  logic               wr_wpos, wr_rpos, wr_mask, wr_color, rd_color, last;
  logic [COMP_W-1:0]  cur_comp;

  always_comb begin
    wr_wpos  = host_wr && (host_sel == SEL_WPOS);
    wr_rpos  = host_wr && (host_sel == SEL_RPOS);
    wr_mask  = host_wr && (host_sel == SEL_MASK);
    wr_color = host_wr && (host_sel == SEL_COLOR);
    rd_color = host_rd && !host_wr && (host_sel == SEL_COLOR);
    last     = (phase_q == PH_BLUE);
    acc_en   = wr_rpos || ((wr_color || rd_color) && last);
    acc_we   = wr_color && last;
    acc_addr = wr_rpos ? host_wdata : pos_q;
    acc_wword = {red_q, grn_q, host_wdata[COMP_W-1:0]};
    case (phase_q)
      PH_RED:   cur_comp = red_q;
      PH_GREEN: cur_comp = grn_q;
      default:  cur_comp = blu_q;
    endcase
    case (host_sel)
      SEL_WPOS, SEL_RPOS: host_rdata = pos_q;
      SEL_COLOR:          host_rdata = {{PAD_W{1'b0}}, cur_comp};
      SEL_MASK:           host_rdata = mask_q;
      default:            host_rdata = '0;
    endcase
  end

  assign pix_mask = mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_RED;
      pos_q   <= '0;
      mask_q  <= '1;
      red_q   <= '0;
      grn_q   <= '0;
      blu_q   <= '0;
    end else if (wr_wpos) begin
      pos_q   <= host_wdata;
      phase_q <= PH_RED;
    end else if (wr_rpos) begin
      pos_q   <= host_wdata + 1'b1;
      phase_q <= PH_RED;
      {red_q, grn_q, blu_q} <= acc_rword;
    end else if (wr_mask) begin
      mask_q <= host_wdata;
    end else if (wr_color) begin
      case (phase_q)
        PH_RED:   red_q <= host_wdata[COMP_W-1:0];
        PH_GREEN: grn_q <= host_wdata[COMP_W-1:0];
        default:  blu_q <= host_wdata[COMP_W-1:0];
      endcase
      if (last) begin
        pos_q   <= pos_q + 1'b1;
        phase_q <= PH_RED;
      end else begin
        phase_q <= phase_t'(phase_q + 2'd1);
      end
    end else if (rd_color) begin
      if (last) begin
        {red_q, grn_q, blu_q} <= acc_rword;
        pos_q   <= pos_q + 1'b1;
        phase_q <= PH_RED;
      end else begin
        phase_q <= phase_t'(phase_q + 2'd1);
      end
    end
  end

  AST_PREFETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rpos |=> (pos_q == $past(host_wdata) + 1'b1)); // R3
  AST_BLUE_WRITE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_color && last) |=> (pos_q == $past(pos_q) + 1'b1) && (phase_q == PH_RED)); // R4
  AST_BLUE_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_color && last) |=> (phase_q == PH_RED) && (pos_q == $past(pos_q) + 1'b1)); // R5
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q)); // R6
  AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel[2]) |=> $stable(pos_q) && $stable(mask_q)); // R10
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 18,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  input  logic [IDX_W-1:0]  pix_mask,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [IDX_W-1:0]  acc_addr,
  input  logic [WORD_W-1:0] acc_wword,
  output logic [WORD_W-1:0] acc_rword,
  output logic              color_valid,
  output logic [WORD_W-1:0] color
);
  logic [WORD_W-1:0] table_q [DEPTH];
  logic [IDX_W-1:0]  look_addr;
  logic [WORD_W-1:0] look_word;
  logic [WORD_W-1:0] color_q;
  logic              valid_q;

  assign look_addr = acc_en ? acc_addr : (pix_idx & pix_mask);
  assign look_word = table_q[look_addr];
  assign acc_rword = look_word;

  always_ff @(posedge clk) begin
    if (acc_en && acc_we) table_q[acc_addr] <= acc_wword;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= pix_valid;
      if (pix_valid && !acc_en) color_q <= look_word;
    end
  end

  assign color       = color_q;
  assign color_valid = valid_q;

  AST_STEAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> $stable(color_q)); // R9
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> valid_q); // R8
endmodule

// File: rtl/clut_engine.sv
module clut_engine #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  localparam int WORD_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_sel,
  input  logic [IDX_W-1:0]  host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [IDX_W-1:0]  host_rdata,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic              color_valid,
  output logic [WORD_W-1:0] color
);
  logic [IDX_W-1:0]  pix_mask;
  logic              acc_en, acc_we;
  logic [IDX_W-1:0]  acc_addr;
  logic [WORD_W-1:0] acc_wword, acc_rword;

  clut_host_regs #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_regs (
    .clk, .rst_n, .host_sel, .host_wdata, .host_wr, .host_rd, .host_rdata,
    .pix_mask, .acc_en, .acc_we, .acc_addr, .acc_wword, .acc_rword
  );

  clut_store #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
    .clk, .rst_n, .pix_valid, .pix_idx, .pix_mask, .acc_en, .acc_we,
    .acc_addr, .acc_wword, .acc_rword, .color_valid, .color
  );

  AST_RD_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel == 3'd1) |-> (host_rdata[7:6] == 2'b00)); // R5
endmodule

// File: tb/tb_clut_engine.sv
module tb_clut_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        color_valid;
  logic [17:0] color;

  int n_cmp = 0;
  int n_bad = 0;
  logic [17:0] exp_mem [256];
  logic [7:0]  rv;

  always #5 clk = ~clk;

  clut_engine dut (
    .clk, .rst_n, .host_sel, .host_wdata, .host_wr, .host_rd, .host_rdata,
    .pix_valid, .pix_idx, .color_valid, .color
  );

  function automatic logic [17:0] ent(int i);
    logic [5:0] r, g, b;
    r = 6'(i & 63);
    g = 6'((i * 5 + 7) & 63);
    b = 6'(((i >> 2) ^ 42) & 63);
    return {r, g, b};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic hw(logic [2:0] sel, logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic hr(logic [2:0] sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic sweep(logic [7:0] m);
    for (int i = 0; i <= 256; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R8 valid", 32'(color_valid), 32'd1);
        chk("R6 R8 color", 32'(color), 32'(exp_mem[(i - 1) & int'(m)]));
      end
      if (i < 256) begin pix_valid = 1'b1; pix_idx = 8'(i); end
      else pix_valid = 1'b0;
    end
    @(negedge clk);
    chk("R8 valid drop", 32'(color_valid), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = ent(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 color", 32'(color), 32'd0);
    chk("R1 valid", 32'(color_valid), 32'd0);
    hr(3'd0, rv); chk("R1 position", 32'(rv), 32'd0);
    hr(3'd2, rv); chk("R1 mask", 32'(rv), 32'hFF);

    hw(3'd0, 8'h37);
    hr(3'd0, rv); chk("R2 pos via 0", 32'(rv), 32'h37);
    hr(3'd3, rv); chk("R2 pos via 3", 32'(rv), 32'h37);

    // fill the whole table through select 1
    hw(3'd0, 8'h00);
    for (int i = 0; i < 256; i++) begin
      hw(3'd1, {2'b11, exp_mem[i][17:12]});
      hw(3'd1, {2'b10, exp_mem[i][11:6]});
      hw(3'd1, {2'b01, exp_mem[i][5:0]});
      if (i == 0) begin hr(3'd0, rv); chk("R4 advance", 32'(rv), 32'd1); end
    end
    hr(3'd0, rv); chk("R4 wrap", 32'(rv), 32'd0);

    // stream the table back out
    hw(3'd3, 8'h00);
    hr(3'd0, rv); chk("R3 prefetch advance", 32'(rv), 32'd1);
    for (int i = 0; i < 256; i++) begin
      hr(3'd1, rv); chk("R5 red", 32'(rv), 32'(exp_mem[i][17:12]));
      hr(3'd1, rv); chk("R5 green", 32'(rv), 32'(exp_mem[i][11:6]));
      hr(3'd1, rv); chk("R5 blue", 32'(rv), 32'(exp_mem[i][5:0]));
    end
    hr(3'd0, rv); chk("R5 wrap", 32'(rv), 32'd1);

    hw(3'd3, 8'hFF);
    hr(3'd0, rv); chk("R3 wrap", 32'(rv), 32'd0);
    hr(3'd1, rv); chk("R3 red", 32'(rv), 32'(exp_mem[255][17:12]));
    hr(3'd1, rv); chk("R3 green", 32'(rv), 32'(exp_mem[255][11:6]));
    hr(3'd1, rv); chk("R3 blue", 32'(rv), 32'(exp_mem[255][5:0]));

    // pixel sweeps under several masks
    hw(3'd2, 8'hFF); hr(3'd2, rv); chk("R6 mask FF", 32'(rv), 32'hFF); sweep(8'hFF);
    hw(3'd2, 8'h0F); hr(3'd2, rv); chk("R6 mask 0F", 32'(rv), 32'h0F); sweep(8'h0F);
    hw(3'd2, 8'hA5); hr(3'd2, rv); chk("R6 mask A5", 32'(rv), 32'hA5); sweep(8'hA5);
    hw(3'd2, 8'h00); hr(3'd2, rv); chk("R6 mask 00", 32'(rv), 32'h00); sweep(8'h00);

    // host accesses ignore the mask
    hw(3'd2, 8'h0F);
    hw(3'd3, 8'hF3);
    hr(3'd0, rv); chk("R7 position", 32'(rv), 32'hF4);
    hr(3'd1, rv); chk("R7 red", 32'(rv), 32'(exp_mem[8'hF3][17:12]));
    hr(3'd1, rv); chk("R7 green", 32'(rv), 32'(exp_mem[8'hF3][11:6]));
    hr(3'd1, rv); chk("R7 blue", 32'(rv), 32'(exp_mem[8'hF3][5:0]));
    hw(3'd2, 8'hFF);

    // R9: prefetch collides with a live pixel
    @(negedge clk); pix_valid = 1'b1; pix_idx = 8'd10;
    @(negedge clk);
    chk("R8 before steal", 32'(color), 32'(exp_mem[10]));
    pix_idx = 8'd20; host_sel = 3'd3; host_wdata = 8'd5; host_wr = 1'b1;
    @(negedge clk);
    chk("R9 hold on prefetch", 32'(color), 32'(exp_mem[10]));
    host_wr = 1'b0; pix_idx = 8'd30;
    @(negedge clk);
    chk("R9 resume", 32'(color), 32'(exp_mem[30]));
    pix_valid = 1'b0;
    hr(3'd1, rv); chk("R3 red after steal", 32'(rv), 32'(exp_mem[5][17:12]));
    hr(3'd1, rv); chk("R3 green after steal", 32'(rv), 32'(exp_mem[5][11:6]));
    hr(3'd1, rv); chk("R3 blue after steal", 32'(rv), 32'(exp_mem[5][5:0]));
    hr(3'd0, rv); chk("R5 position after blue read", 32'(rv), 32'd7);

    // R9: blue write collides with a live pixel
    hw(3'd0, 8'h40);
    hw(3'd1, 8'h01);
    hw(3'd1, 8'h02);
    @(negedge clk); pix_valid = 1'b1; pix_idx = 8'd7;
    @(negedge clk);
    chk("R8 before blue", 32'(color), 32'(exp_mem[7]));
    pix_idx = 8'h40; host_sel = 3'd1; host_wdata = 8'h03; host_wr = 1'b1;
    @(negedge clk);
    chk("R9 hold on blue write", 32'(color), 32'(exp_mem[7]));
    host_wr = 1'b0;
    exp_mem[8'h40] = {6'd1, 6'd2, 6'd3};
    @(negedge clk);
    chk("R4 stored entry", 32'(color), 32'(exp_mem[8'h40]));
    pix_valid = 1'b0;
    hr(3'd0, rv); chk("R4 position", 32'(rv), 32'h41);

    // R10: unused selects
    hw(3'd2, 8'h5A);
    hw(3'd4, 8'h99); hw(3'd5, 8'h12); hw(3'd6, 8'h34); hw(3'd7, 8'h56);
    for (int s = 4; s < 8; s++) begin
      hr(3'(s), rv); chk("R10 reads zero", 32'(rv), 32'd0);
    end
    hr(3'd0, rv); chk("R10 position kept", 32'(rv), 32'h41);
    hr(3'd2, rv); chk("R10 mask kept", 32'(rv), 32'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule